// File: doc/BRIEF.md
# Branch History Table Predictor

This block is a direct-mapped branch history table that the fetch stage consults on every fetch address. Each entry keeps a tag taken from the upper bits of the branch address, a short outcome history and the branch destination. A lookup is combinational. On a hit it returns the predicted direction and the stored destination, so fetch can redirect without waiting for the target to be computed. On a miss it falls back to a fixed not-taken guess.

When a branch resolves, the execute stage reports its address, its outcome and its destination. The table then updates that branch's history and target. A branch that is not yet in the table gets an entry only if it was taken. An elaboration parameter selects the history scheme. The one-bit scheme repeats the last outcome. The two-bit scheme is a saturating counter that needs two mispredictions in a row before the prediction flips.

Top module: `bht_predictor`

## Requirements
- R1: After reset, and while reset is held, every entry is empty and every lookup misses.
- R2: On a miss, `lk_hit_o`, `lk_taken_o` and `lk_target_o` are all zero (static predict-not-taken).
- R3: A taken resolve for an address that misses creates an entry with that address's tag and target. In two-bit mode the counter starts at 2 (weakly taken). In one-bit mode the bit starts at 1. The next lookup of that address hits, predicts taken and returns that target.
- R4: A not-taken resolve for an address that misses writes nothing. That address still misses, and any entry with another tag at the same index keeps its contents.
- R5: In two-bit mode the counter saturates at 0 and 3. It moves up on taken and down on not-taken, and predicts taken when its value is 2 or 3. From a strong state, the prediction flips only after two consecutive opposite outcomes.
- R6: In one-bit mode, the prediction on a hit equals the outcome of the most recent resolve of that branch.
- R7: A hit returns the stored target. A taken resolve on a hit replaces the target with the reported one. A not-taken resolve leaves the target unchanged.
- R8: The index is PC bits [OFS_W+IDX_W-1:OFS_W] and the tag is the bits above the index. A lookup whose index matches but whose tag differs misses. A taken resolve with a different tag at an occupied index replaces the occupant.
- R9: A lookup always returns the table state from before any resolve in the same cycle, including a resolve to the same index. The resolve's result is stored at that clock edge. With no resolve and an unchanged lookup address, the outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lk_pc_i | input | PC_W | Fetch address to look up |
| lk_hit_o | output | 1 | Lookup matched a valid entry |
| lk_taken_o | output | 1 | Predicted direction |
| lk_target_o | output | PC_W | Predicted destination (zero on miss) |
| upd_valid_i | input | 1 | A branch resolves this cycle |
| upd_pc_i | input | PC_W | Address of the resolved branch |
| upd_taken_i | input | 1 | Resolved outcome |
| upd_target_i | input | PC_W | Resolved destination |

## Verification
The assertions check the following on every cycle:
- the zeroed miss response;
- the empty table right after reset;
- that a taken resolve of a missing address is visible as a taken hit with the reported target on the next cycle;
- that a not-taken resolve of a missing address leaves it missing;
- that the outputs stay steady while nothing resolves.

Some behaviour shows only in the bench's ordered scenarios, because it depends on a history of several resolves:
- counter saturation and the two-mispredict hysteresis;
- one-bit flipping;
- replacement of the target on taken resolves only;
- eviction on a tag conflict;
- the old value returned during a same-cycle resolve.

// File: rtl/bht_pkg.sv
`timescale 1ns/1ps
package bht_pkg;
  typedef enum logic {
    HIST_ONE = 1'b0,
    HIST_TWO = 1'b1
  } hist_mode_e;

  function automatic int unsigned hist_width(hist_mode_e m);
    return (m == HIST_TWO) ? 2 : 1;
  endfunction
endpackage

// File: rtl/bht_pc_split.sv
`timescale 1ns/1ps
// Splits a PC into table index and tag; low OFS_W bits are alignment only.
module bht_pc_split #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned OFS_W = 2,
  parameter int unsigned IDX_W = 4,
  localparam int unsigned TAG_W = PC_W - OFS_W - IDX_W
) (
  input  logic [PC_W-1:0]  pc_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [TAG_W-1:0] tag_o
);
  logic unused_ofs;
  assign unused_ofs = ^pc_i[OFS_W-1:0];
  assign idx_o = pc_i[OFS_W +: IDX_W];
  assign tag_o = pc_i[PC_W-1 -: TAG_W];
endmodule

// File: rtl/bht_hist_ops.sv
`timescale 1ns/1ps
// History next-state and direction decode, variant picked by HIST_MODE.
module bht_hist_ops
  import bht_pkg::*;
#(
  parameter hist_mode_e HIST_MODE = HIST_TWO,
  localparam int unsigned HIST_W = hist_width(HIST_MODE)
) (
  input  logic [HIST_W-1:0] cur_hist_i,
  input  logic              cur_hit_i,
  input  logic              taken_i,
  output logic [HIST_W-1:0] next_hist_o,
  input  logic [HIST_W-1:0] rd_hist_i,
  output logic              pred_o
);
  generate
    if (HIST_MODE == HIST_TWO) begin : g_two
      always_comb begin
        if (!cur_hit_i)
          next_hist_o = 2'b10;                      // weakly taken on allocate
        else if (taken_i)
          next_hist_o = (cur_hist_i == 2'b11) ? 2'b11 : cur_hist_i + 2'b01;
        else
          next_hist_o = (cur_hist_i == 2'b00) ? 2'b00 : cur_hist_i - 2'b01;
      end
      assign pred_o = rd_hist_i[1];
    end else begin : g_one
      logic unused_hist;
      assign unused_hist = cur_hist_i[0] ^ cur_hit_i;
      assign next_hist_o = taken_i;
      assign pred_o      = rd_hist_i[0];
    end
  endgenerate
endmodule

// File: rtl/bht_table.sv
`timescale 1ns/1ps
// Entry storage: one write port, two combinational read ports.
module bht_table #(
  parameter int unsigned PC_W   = 32,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned TAG_W  = 26,
  parameter int unsigned HIST_W = 2,
  localparam int unsigned DEPTH = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  ra_idx_i,
  output logic              ra_valid_o,
  output logic [TAG_W-1:0]  ra_tag_o,
  output logic [HIST_W-1:0] ra_hist_o,
  output logic [PC_W-1:0]   ra_tgt_o,
  input  logic [IDX_W-1:0]  rb_idx_i,
  output logic              rb_valid_o,
  output logic [TAG_W-1:0]  rb_tag_o,
  output logic [HIST_W-1:0] rb_hist_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [HIST_W-1:0] wr_hist_i,
  input  logic              wr_tgt_en_i,
  input  logic [PC_W-1:0]   wr_tgt_i
);
  logic [DEPTH-1:0]  valid_a;
  logic [TAG_W-1:0]  tag_a  [DEPTH];
  logic [HIST_W-1:0] hist_a [DEPTH];
  logic [PC_W-1:0]   tgt_a  [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic              valid_q;
    logic [TAG_W-1:0]  tag_q;
    logic [HIST_W-1:0] hist_q;
    logic [PC_W-1:0]   tgt_q;
    logic              sel;
    assign sel = wr_en_i && (wr_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q <= 1'b0;
        tag_q   <= '0;
        hist_q  <= '0;
        tgt_q   <= '0;
      end else if (sel) begin
        valid_q <= 1'b1;
        tag_q   <= wr_tag_i;
        hist_q  <= wr_hist_i;
        if (wr_tgt_en_i) tgt_q <= wr_tgt_i;
      end
    end

    assign valid_a[g] = valid_q;
    assign tag_a[g]   = tag_q;
    assign hist_a[g]  = hist_q;
    assign tgt_a[g]   = tgt_q;
  end

  assign ra_valid_o = valid_a[ra_idx_i];
  assign ra_tag_o   = tag_a[ra_idx_i];
  assign ra_hist_o  = hist_a[ra_idx_i];
  assign ra_tgt_o   = tgt_a[ra_idx_i];
  assign rb_valid_o = valid_a[rb_idx_i];
  assign rb_tag_o   = tag_a[rb_idx_i];
  assign rb_hist_o  = hist_a[rb_idx_i];
endmodule

// File: rtl/bht_predictor.sv
`timescale 1ns/1ps
module bht_predictor
  import bht_pkg::*;
#(
  parameter int unsigned PC_W      = 32,
  parameter int unsigned OFS_W     = 2,
  parameter int unsigned IDX_W     = 4,
  parameter hist_mode_e  HIST_MODE = HIST_TWO
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] lk_pc_i,
  output logic            lk_hit_o,
  output logic            lk_taken_o,
  output logic [PC_W-1:0] lk_target_o,
  input  logic            upd_valid_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic            upd_taken_i,
  input  logic [PC_W-1:0] upd_target_i
);
  localparam int unsigned TAG_W  = PC_W - OFS_W - IDX_W;
  localparam int unsigned HIST_W = hist_width(HIST_MODE);

  logic [IDX_W-1:0]  lk_idx, up_idx;
  logic [TAG_W-1:0]  lk_tag, up_tag;
  logic              ra_valid, rb_valid;
  logic [TAG_W-1:0]  ra_tag, rb_tag;
  logic [HIST_W-1:0] ra_hist, rb_hist, wr_hist;
  logic [PC_W-1:0]   ra_tgt;
  logic              lk_hit, up_hit, pred, wr_en;

  bht_pc_split #(.PC_W(PC_W), .OFS_W(OFS_W), .IDX_W(IDX_W)) u_lk_split (
    .pc_i(lk_pc_i), .idx_o(lk_idx), .tag_o(lk_tag)
  );
  bht_pc_split #(.PC_W(PC_W), .OFS_W(OFS_W), .IDX_W(IDX_W)) u_up_split (
    .pc_i(upd_pc_i), .idx_o(up_idx), .tag_o(up_tag)
  );

  assign lk_hit = ra_valid && (ra_tag == lk_tag);
  assign up_hit = rb_valid && (rb_tag == up_tag);
  // allocate only on a taken outcome; hits always update
  assign wr_en  = upd_valid_i && (up_hit || upd_taken_i);

  bht_hist_ops #(.HIST_MODE(HIST_MODE)) u_hist (
    .cur_hist_i (rb_hist),
    .cur_hit_i  (up_hit),
    .taken_i    (upd_taken_i),
    .next_hist_o(wr_hist),
    .rd_hist_i  (ra_hist),
    .pred_o     (pred)
  );

  bht_table #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .HIST_W(HIST_W)) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ra_idx_i   (lk_idx),
    .ra_valid_o (ra_valid),
    .ra_tag_o   (ra_tag),
    .ra_hist_o  (ra_hist),
    .ra_tgt_o   (ra_tgt),
    .rb_idx_i   (up_idx),
    .rb_valid_o (rb_valid),
    .rb_tag_o   (rb_tag),
    .rb_hist_o  (rb_hist),
    .wr_en_i    (wr_en),
    .wr_idx_i   (up_idx),
    .wr_tag_i   (up_tag),
    .wr_hist_i  (wr_hist),
    .wr_tgt_en_i(upd_taken_i),
    .wr_tgt_i   (upd_target_i)
  );

  assign lk_hit_o    = lk_hit;
  assign lk_taken_o  = lk_hit && pred;
  assign lk_target_o = lk_hit ? ra_tgt : '0;
endmodule

// File: rtl/bht_predictor_chk.sv
`timescale 1ns/1ps
module bht_predictor_chk #(
  parameter int unsigned PC_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [PC_W-1:0] lk_pc_i,
  input logic            lk_hit_o,
  input logic            lk_taken_o,
  input logic [PC_W-1:0] lk_target_o,
  input logic            upd_valid_i,
  input logic [PC_W-1:0] upd_pc_i,
  input logic            upd_taken_i,
  input logic [PC_W-1:0] upd_target_i
);
  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  a_r1_empty_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |-> !lk_hit_o);

  a_r2_static_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_hit_o |-> (!lk_taken_o && lk_target_o == '0));

  a_r3_alloc_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(upd_valid_i && upd_taken_i && !lk_hit_o && lk_pc_i == upd_pc_i)
     && lk_pc_i == $past(upd_pc_i))
    |-> (lk_hit_o && lk_taken_o && lk_target_o == $past(upd_target_i)));

  a_r4_no_alloc_not_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(upd_valid_i && !upd_taken_i && !lk_hit_o && lk_pc_i == upd_pc_i)
     && lk_pc_i == $past(upd_pc_i))
    |-> !lk_hit_o);

  a_r9_stable_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(!upd_valid_i) && $stable(lk_pc_i))
    |-> ($stable(lk_hit_o) && $stable(lk_taken_o) && $stable(lk_target_o)));
endmodule

bind bht_predictor bht_predictor_chk #(.PC_W(PC_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .lk_pc_i     (lk_pc_i),
  .lk_hit_o    (lk_hit_o),
  .lk_taken_o  (lk_taken_o),
  .lk_target_o (lk_target_o),
  .upd_valid_i (upd_valid_i),
  .upd_pc_i    (upd_pc_i),
  .upd_taken_i (upd_taken_i),
  .upd_target_i(upd_target_i)
);

// File: tb/bht_predictor_tb.sv
`timescale 1ns/1ps
module bht_predictor_tb;
  import bht_pkg::*;

  typedef struct packed {
    logic        uv;
    logic [31:0] upc;
    logic        ut;
    logic [31:0] utg;
    logic [31:0] lpc;
    logic        eh;
    logic        et;
    logic [31:0] etg;
    logic [3:0]  req;
  } vec_t;

  localparam logic [31:0] PA = 32'h0000_1004; // idx 1
  localparam logic [31:0] PB = 32'h0000_2004; // idx 1, other tag
  localparam logic [31:0] PC = 32'h0000_0100; // idx 0
  localparam logic [31:0] Z  = 32'h0;
  localparam int NV = 27;

  // Two-bit mode. Expected lookup is the state before this step's resolve.
  localparam vec_t VECS [NV] = '{
    '{1'b0, Z,  1'b0, Z,            PA, 1'b0, 1'b0, Z,            4'd1}, // R1
    '{1'b1, PA, 1'b0, Z,            PA, 1'b0, 1'b0, Z,            4'd4}, // R4
    '{1'b0, Z,  1'b0, Z,            PA, 1'b0, 1'b0, Z,            4'd4}, // R4
    '{1'b1, PA, 1'b1, 32'h2000,     PA, 1'b0, 1'b0, Z,            4'd9}, // R9 old value
    '{1'b0, Z,  1'b0, Z,            PA, 1'b1, 1'b1, 32'h2000,     4'd3}, // R3 weak taken
    '{1'b1, PA, 1'b0, Z,            PA, 1'b1, 1'b1, 32'h2000,     4'd9}, // ->1
    '{1'b0, Z,  1'b0, Z,            PA, 1'b1, 1'b0, 32'h2000,     4'd7}, // R7 target kept
    '{1'b1, PA, 1'b1, 32'h3000,     PA, 1'b1, 1'b0, 32'h2000,     4'd5}, // ->2
    '{1'b1, PA, 1'b1, 32'h3000,     PA, 1'b1, 1'b1, 32'h3000,     4'd7}, // R7 replaced, ->3
    '{1'b1, PA, 1'b0, Z,            PA, 1'b1, 1'b1, 32'h3000,     4'd5}, // ->2
    '{1'b0, Z,  1'b0, Z,            PA, 1'b1, 1'b1, 32'h3000,     4'd5}, // R5 hysteresis
    '{1'b1, PA, 1'b1, 32'h3000,     PA, 1'b1, 1'b1, 32'h3000,     4'd5}, // ->3
    '{1'b1, PA, 1'b1, 32'h3000,     PA, 1'b1, 1'b1, 32'h3000,     4'd5}, // sat 3
    '{1'b1, PA, 1'b0, Z,            PA, 1'b1, 1'b1, 32'h3000,     4'd5}, // ->2
    '{1'b1, PA, 1'b0, Z,            PA, 1'b1, 1'b1, 32'h3000,     4'd5}, // ->1
    '{1'b0, Z,  1'b0, Z,            PA, 1'b1, 1'b0, 32'h3000,     4'd5}, // R5 flipped
    '{1'b1, PA, 1'b0, Z,            PA, 1'b1, 1'b0, 32'h3000,     4'd5}, // ->0
    '{1'b1, PA, 1'b0, Z,            PA, 1'b1, 1'b0, 32'h3000,     4'd5}, // sat 0
    '{1'b1, PA, 1'b1, 32'h3000,     PA, 1'b1, 1'b0, 32'h3000,     4'd5}, // ->1
    '{1'b0, Z,  1'b0, Z,            PA, 1'b1, 1'b0, 32'h3000,     4'd5}, // R5 still not taken
    '{1'b1, PB, 1'b1, 32'h4000,     PA, 1'b1, 1'b0, 32'h3000,     4'd8}, // R8 evict
    '{1'b0, Z,  1'b0, Z,            PA, 1'b0, 1'b0, Z,            4'd8}, // R8 tag mismatch
    '{1'b0, Z,  1'b0, Z,            PB, 1'b1, 1'b1, 32'h4000,     4'd8},
    '{1'b1, PA, 1'b0, Z,            PB, 1'b1, 1'b1, 32'h4000,     4'd4}, // R4 occupant kept
    '{1'b0, Z,  1'b0, Z,            PB, 1'b1, 1'b1, 32'h4000,     4'd4},
    '{1'b1, PC, 1'b0, Z,            PC, 1'b0, 1'b0, Z,            4'd4},
    '{1'b0, Z,  1'b0, Z,            PC, 1'b0, 1'b0, Z,            4'd2}  // R2
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] lk_pc = '0, upd_pc = '0, upd_target = '0;
  logic        upd_valid = 1'b0, upd_taken = 1'b0;
  logic        lk_hit, lk_taken;
  logic [31:0] lk_target;
  logic [31:0] o_lk_pc = '0, o_upd_pc = '0, o_upd_target = '0;
  logic        o_upd_valid = 1'b0, o_upd_taken = 1'b0;
  logic        o_hit, o_taken;
  logic [31:0] o_target;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bht_predictor #(.HIST_MODE(HIST_TWO)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .lk_pc_i(lk_pc), .lk_hit_o(lk_hit),
    .lk_taken_o(lk_taken), .lk_target_o(lk_target), .upd_valid_i(upd_valid),
    .upd_pc_i(upd_pc), .upd_taken_i(upd_taken), .upd_target_i(upd_target)
  );

  bht_predictor #(.HIST_MODE(HIST_ONE)) u_dut_1b (
    .clk_i(clk), .rst_ni(rst_ni), .lk_pc_i(o_lk_pc), .lk_hit_o(o_hit),
    .lk_taken_o(o_taken), .lk_target_o(o_target), .upd_valid_i(o_upd_valid),
    .upd_pc_i(o_upd_pc), .upd_taken_i(o_upd_taken), .upd_target_i(o_upd_target)
  );

  task automatic chk(input string req, input logic gh, input logic gt, input logic [31:0] gtg,
                     input logic eh, input logic et, input logic [31:0] etg);
    checks++;
    if (gh !== eh || gt !== et || gtg !== etg) begin
      errors++;
      $display("FAIL %s: hit/taken/target got %b/%b/%h expected %b/%b/%h",
               req, gh, gt, gtg, eh, et, etg);
    end
  endtask

  task automatic step1(input logic uv, input logic [31:0] pc, input logic t, input logic [31:0] tg,
                       input logic eh, input logic et, input logic [31:0] etg, input string req);
    @(negedge clk);
    o_upd_valid = uv; o_upd_pc = pc; o_upd_taken = t; o_upd_target = tg; o_lk_pc = pc;
    #1;
    chk(req, o_hit, o_taken, o_target, eh, et, etg);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 in reset", lk_hit, lk_taken, lk_target, 1'b0, 1'b0, Z);
    @(negedge clk);
    rst_ni = 1'b1;

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      upd_valid = VECS[k].uv; upd_pc = VECS[k].upc; upd_taken = VECS[k].ut;
      upd_target = VECS[k].utg; lk_pc = VECS[k].lpc;
      #1;
      chk($sformatf("R%0d step %0d", VECS[k].req, k), lk_hit, lk_taken, lk_target,
          VECS[k].eh, VECS[k].et, VECS[k].etg);
    end
    @(negedge clk);
    upd_valid = 1'b0;

    // one-bit mode
    step1(1'b1, 32'h40, 1'b1, 32'h500, 1'b0, 1'b0, Z,        "R3 1b alloc");
    step1(1'b0, 32'h40, 1'b0, Z,       1'b1, 1'b1, 32'h500,  "R3 1b hit");
    step1(1'b1, 32'h40, 1'b0, Z,       1'b1, 1'b1, 32'h500,  "R6 1b before");
    step1(1'b0, 32'h40, 1'b0, Z,       1'b1, 1'b0, 32'h500,  "R6 1b flip nt");
    step1(1'b1, 32'h40, 1'b1, 32'h600, 1'b1, 1'b0, 32'h500,  "R6 1b before");
    step1(1'b0, 32'h40, 1'b0, Z,       1'b1, 1'b1, 32'h600,  "R6 1b flip t");
    @(negedge clk);
    o_upd_valid = 1'b0;

    // reset mid-run clears populated entries
    @(negedge clk);
    lk_pc = PB;
    #1;
    chk("R1 populated", lk_hit, lk_taken, lk_target, 1'b1, 1'b1, 32'h4000);
    rst_ni = 1'b0;
    #1;
    chk("R1 async clear", lk_hit, lk_taken, lk_target, 1'b0, 1'b0, Z);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    #1;
    chk("R1 after reset", lk_hit, lk_taken, lk_target, 1'b0, 1'b0, Z);
    o_lk_pc = 32'h40;
    #1;
    chk("R1 1b after reset", o_hit, o_taken, o_target, 1'b0, 1'b0, Z);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule